// File: doc/BRIEF.md
# Serial DAC Command Frame Transmitter

This block is the host end of a three-wire link to a dual-channel voltage DAC. A parallel request carries a channel select, a two-bit operation code, a 12-bit code and a byte-split flag. When the block is idle, a one-cycle start pulse accepts the request. The block packs the request into a 16-bit command word and sends it most significant bit first. The block drives a serial clock divided down from the system clock, an active-low frame select and a data line. The receiver samples data on the falling serial clock edge, which is clock polarity 0 with phase 1.

Each frame begins with frame select high for a programmable number of system clocks, which gives the receiver a clean falling edge to open the frame. Frame select then falls while the serial clock is low. Data changes only on rising serial clock edges. After the sixteenth falling edge, frame select rises and is held high for the same programmable time. Then the line returns to the low-power idle state, with all three outputs low. In byte-split mode the clock pauses after the eighth bit while frame select stays low. This imitates a controller that transmits whole bytes.

Top module: `dacfrm_tx`

## Requirements
- R1: The frame is 16 bits, sent most significant bit first with exactly 16 falling serial clock edges while frame select is low. Bit 15 is 0, bit 14 is the channel select, bits 13:12 are the operation code and bits 11:0 are the data code.
- R2: The serial clock idles low and toggles only while frame select is low. Each high phase and each low phase lasts HALF_DIV system clocks, except for the byte gap described in R10.
- R3: The data line changes only together with a rising serial clock edge, or when frame select rises at the end of a frame. It is stable while the serial clock is high.
- R4: Frame select falls only while the serial clock is low, never in the same cycle as a falling serial clock edge. It falls at least HALF_DIV system clocks before the first rising edge.
- R5: Frame select rises at least HALF_DIV system clocks after the sixteenth falling edge.
- R6: Each high period of frame select, both before and after a frame, lasts exactly GAP_CLKS system clocks.
- R7: After reset, and whenever the block is idle, frame select, serial clock, data line and busy are all low. An asynchronous reset at any point returns the block to this state.
- R8: Busy goes high in the cycle after a start is accepted. It falls in the same cycle as the falling frame select edge that ends the post-frame high time.
- R9: A start while busy is ignored and produces no additional frame. The request fields are captured when the start is accepted, so later changes at the inputs do not alter the frame in flight.
- R10: With the split flag set when the frame is accepted, the serial clock stays low for (BYTE_GAP+1)*HALF_DIV system clocks after the eighth falling edge, and frame select stays low across this gap. With the flag clear, this interval is HALF_DIV.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| arst_n_i | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | Request strobe, accepted only while idle |
| chan_i | input | 1 | Channel select, placed in frame bit 14 |
| mode_i | input | 2 | Operation code, placed in frame bits 13:12 |
| data_i | input | 12 | Output code, placed in frame bits 11:0 |
| split_i | input | 1 | Send the frame as two 8-clock bursts |
| busy_o | output | 1 | High from acceptance until the post-frame select-high time ends |
| sck_o | output | 1 | Serial clock to the DAC |
| fs_n_o | output | 1 | Active-low frame select to the DAC |
| sdo_o | output | 1 | Serial data to the DAC |

## Verification
The bench builds the block with HALF_DIV=3, GAP_CLKS=5 and BYTE_GAP=3 instead of the defaults. An odd divide ratio gives high and low phases that a wrong off-by-one count in the phase counter would change. A select-high time that is unequal to the divide ratio or the byte gap lets a mixed-up counter load show up as a wrong duration. With the byte gap greater than one, the paused interval of a split frame, (3+1)*3 = 12 clocks, is clearly different from the 3-clock interval of a plain frame.

// File: rtl/dacfrm_pkg.sv
`timescale 1ns/1ps
package dacfrm_pkg;

  localparam int FRAME_W  = 16;
  localparam int DATA_W   = 12;
  localparam int MODE_W   = 2;
  localparam int SPLIT_AT = 8;
  localparam int BIT_W    = $clog2(FRAME_W);

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PRE   = 3'd1,
    ST_LEAD  = 3'd2,
    ST_SHIFT = 3'd3,
    ST_BGAP  = 3'd4,
    ST_TAIL  = 3'd5,
    ST_POST  = 3'd6
  } tx_state_e;

  // Field positions are fixed by the receiver's decoder.
  function automatic logic [FRAME_W-1:0] pack_frame(
    input logic              chan,
    input logic [MODE_W-1:0] mode,
    input logic [DATA_W-1:0] code
  );
    return {1'b0, chan, mode, code};
  endfunction

endpackage

// File: rtl/dacfrm_rst_sync.sv
`timescale 1ns/1ps
module dacfrm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_n_i,
  output logic rst_n_o
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge arst_n_i) begin
        if (!arst_n_i) chain_q <= 1'b0;
        else           chain_q <= 1'b1;
      end
    end else begin : g_multi
      always_ff @(posedge clk_i or negedge arst_n_i) begin
        if (!arst_n_i) chain_q <= '0;
        else           chain_q <= {chain_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_n_o = chain_q[STAGES-1];

endmodule

// File: rtl/dacfrm_halfper.sv
`timescale 1ns/1ps
module dacfrm_halfper #(
  parameter int HALF_DIV = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic run_i,
  output logic tick_o
);

  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          wrap;

  assign wrap   = (cnt_q == LAST);
  assign tick_o = run_i && wrap;

  always_comb begin
    if (!run_i)    cnt_d = '0;
    else if (wrap) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) cnt_q <= '0;
    else          cnt_q <= cnt_d;
  end

endmodule

// File: rtl/dacfrm_downcnt.sv
`timescale 1ns/1ps
module dacfrm_downcnt #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_n_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         en_i,
  output logic         zero_o
);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_ce;

  assign zero_o = (cnt_q == '0);
  assign cnt_ce = load_i || (en_i && !zero_o);

  always_comb begin
    if (load_i) cnt_d = load_val_i;
    else        cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)    cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/dacfrm_shreg.sv
`timescale 1ns/1ps
module dacfrm_shreg #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_n_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         shift_i,
  output logic         msb_o
);

  logic [W-1:0] sr_q, sr_d;
  logic         sr_ce;

  assign sr_ce = load_i || shift_i;
  assign msb_o = sr_q[W-1];

  always_comb begin
    if (load_i) sr_d = load_val_i;
    else        sr_d = {sr_q[W-2:0], 1'b0};
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)   sr_q <= '0;
    else if (sr_ce) sr_q <= sr_d;
  end

endmodule

// File: rtl/dacfrm_tx.sv
`timescale 1ns/1ps
module dacfrm_tx
  import dacfrm_pkg::*;
#(
  parameter int HALF_DIV   = 2,
  parameter int GAP_CLKS   = 8,
  parameter int BYTE_GAP   = 2,
  parameter int RST_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              arst_n_i,
  input  logic              start_i,
  input  logic              chan_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              split_i,
  output logic              busy_o,
  output logic              sck_o,
  output logic              fs_n_o,
  output logic              sdo_o
);

  localparam int CMAX = (GAP_CLKS > BYTE_GAP) ? GAP_CLKS : BYTE_GAP;
  localparam int CW   = $clog2(CMAX + 1);
  localparam logic [CW-1:0]    GAP_LOAD  = CW'(GAP_CLKS - 1);
  localparam logic [CW-1:0]    BGAP_LOAD = CW'(BYTE_GAP - 1);
  localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(FRAME_W - 1);
  localparam logic [BIT_W-1:0] MID_BIT   = BIT_W'(SPLIT_AT - 1);

  logic rst_n;

  tx_state_e        st_q, st_d;
  logic             fsn_q, fsn_d;
  logic             sck_q, sck_d;
  logic             sdo_q, sdo_d;
  logic             split_q, split_d;
  logic [BIT_W-1:0] bcnt_q, bcnt_d;

  logic          run, tick;
  logic          sh_load, sh_shift, sh_msb;
  logic          cnt_load, cnt_en, cnt_zero;
  logic [CW-1:0] cnt_val;

  dacfrm_rst_sync #(.STAGES(RST_STAGES)) i_rst_sync (
    .clk_i    (clk_i),
    .arst_n_i (arst_n_i),
    .rst_n_o  (rst_n)
  );

  dacfrm_halfper #(.HALF_DIV(HALF_DIV)) i_halfper (
    .clk_i   (clk_i),
    .rst_n_i (rst_n),
    .run_i   (run),
    .tick_o  (tick)
  );

  dacfrm_downcnt #(.W(CW)) i_gapcnt (
    .clk_i      (clk_i),
    .rst_n_i    (rst_n),
    .load_i     (cnt_load),
    .load_val_i (cnt_val),
    .en_i       (cnt_en),
    .zero_o     (cnt_zero)
  );

  dacfrm_shreg #(.W(FRAME_W)) i_shreg (
    .clk_i      (clk_i),
    .rst_n_i    (rst_n),
    .load_i     (sh_load),
    .load_val_i (pack_frame(chan_i, mode_i, data_i)),
    .shift_i    (sh_shift),
    .msb_o      (sh_msb)
  );

  assign run = (st_q == ST_LEAD) || (st_q == ST_SHIFT) ||
               (st_q == ST_BGAP) || (st_q == ST_TAIL);

  // Next-state logic
  always_comb begin
    st_d     = st_q;
    fsn_d    = fsn_q;
    sck_d    = sck_q;
    sdo_d    = sdo_q;
    split_d  = split_q;
    bcnt_d   = bcnt_q;
    sh_load  = 1'b0;
    sh_shift = 1'b0;
    cnt_load = 1'b0;
    cnt_val  = '0;
    cnt_en   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          st_d     = ST_PRE;
          fsn_d    = 1'b1;
          split_d  = split_i;
          sh_load  = 1'b1;
          cnt_load = 1'b1;
          cnt_val  = GAP_LOAD;
        end
      end
      ST_PRE: begin
        cnt_en = 1'b1;
        if (cnt_zero) begin
          st_d  = ST_LEAD;
          fsn_d = 1'b0;
        end
      end
      ST_LEAD: begin
        if (tick) begin
          st_d     = ST_SHIFT;
          sck_d    = 1'b1;
          sdo_d    = sh_msb;
          sh_shift = 1'b1;
          bcnt_d   = '0;
        end
      end
      ST_SHIFT: begin
        if (tick) begin
          if (sck_q) begin
            sck_d = 1'b0;
            if (bcnt_q == LAST_BIT) begin
              st_d = ST_TAIL;
            end else if (split_q && (bcnt_q == MID_BIT)) begin
              st_d     = ST_BGAP;
              cnt_load = 1'b1;
              cnt_val  = BGAP_LOAD;
            end
          end else begin
            sck_d    = 1'b1;
            sdo_d    = sh_msb;
            sh_shift = 1'b1;
            bcnt_d   = bcnt_q + 1'b1;
          end
        end
      end
      ST_BGAP: begin
        cnt_en = tick;
        if (tick && cnt_zero) st_d = ST_SHIFT;
      end
      ST_TAIL: begin
        if (tick) begin
          st_d     = ST_POST;
          fsn_d    = 1'b1;
          sdo_d    = 1'b0;
          cnt_load = 1'b1;
          cnt_val  = GAP_LOAD;
        end
      end
      ST_POST: begin
        cnt_en = 1'b1;
        if (cnt_zero) begin
          st_d  = ST_IDLE;
          fsn_d = 1'b0;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // State registers
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      fsn_q   <= 1'b0;
      sck_q   <= 1'b0;
      sdo_q   <= 1'b0;
      split_q <= 1'b0;
      bcnt_q  <= '0;
    end else begin
      st_q    <= st_d;
      fsn_q   <= fsn_d;
      sck_q   <= sck_d;
      sdo_q   <= sdo_d;
      split_q <= split_d;
      bcnt_q  <= bcnt_d;
    end
  end

  assign busy_o = (st_q != ST_IDLE);
  assign sck_o  = sck_q;
  assign fs_n_o = fsn_q;
  assign sdo_o  = sdo_q;

  AST_SCK_FRAMED: assert property (@(posedge clk_i) disable iff (!rst_n) sck_q |-> !fsn_q); // R2
  AST_SDO_HOLD: assert property (@(posedge clk_i) disable iff (!rst_n) (sck_q && $past(sck_q)) |-> $stable(sdo_q)); // R3
  AST_FS_FALL_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_n) $fell(fsn_q) |-> (!sck_q && !$past(sck_q))); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_n) (st_q == ST_IDLE) |-> (!sck_q && !sdo_q && !fsn_q)); // R7
  AST_BUSY_ON_START: assert property (@(posedge clk_i) disable iff (!rst_n) ((st_q == ST_IDLE) && start_i) |=> busy_o); // R8
  AST_BGAP_HELD: assert property (@(posedge clk_i) disable iff (!rst_n) (st_q == ST_BGAP) |-> (!sck_q && !fsn_q)); // R10

endmodule

// File: tb/test_dacfrm_tx.sv
`timescale 1ns/1ps
module test_dacfrm_tx;

  localparam int H  = 3;
  localparam int G  = 5;
  localparam int BG = 3;

  // {split, chan, mode[1:0], data[11:0]} , expected frame word
  localparam logic [31:0] VEC [8] = '{
    {16'h0000, 16'h0000},
    {16'h5FFF, 16'h5FFF},
    {16'hAA5C, 16'h2A5C},
    {16'hF001, 16'h7001},
    {16'h3800, 16'h3800},
    {16'h4555, 16'h4555},
    {16'h93C3, 16'h13C3},
    {16'hEFFF, 16'h6FFF}
  };

  logic        clk = 1'b0;
  logic        arst_n;
  logic        start;
  logic        chan;
  logic [1:0]  mode;
  logic [11:0] data;
  logic        split;
  logic        busy, sck, fsn, sdo;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  dacfrm_tx #(.HALF_DIV(H), .GAP_CLKS(G), .BYTE_GAP(BG)) i_dacfrm_tx (
    .clk_i    (clk),
    .arst_n_i (arst_n),
    .start_i  (start),
    .chan_i   (chan),
    .mode_i   (mode),
    .data_i   (data),
    .split_i  (split),
    .busy_o   (busy),
    .sck_o    (sck),
    .fs_n_o   (fsn),
    .sdo_o    (sdo)
  );

  // Line monitor, sampled on the falling system clock edge
  int          cyc, last_rise, last_fall, fs_fall_cyc, fs_rise_cyc, fcnt, gap8;
  int          frames, last_fcnt;
  int          e_r2, e_r3, e_r4, e_r5, e_r6, e_r7, e_r8;
  logic [15:0] cap, last_cap;
  logic        psck, pfsn, psdo, pbusy, seen_rise;
  logic        rise, fall, sel, desel;

  always @(negedge clk) begin
    if (!arst_n) begin
      psck = 0; pfsn = 0; psdo = 0; pbusy = 0; seen_rise = 0;
      fcnt = 0; cap = '0; cyc = 0;
      last_rise = 0; last_fall = 0; fs_fall_cyc = 0; fs_rise_cyc = 0;
    end else begin
      cyc++;
      rise  = !psck && sck;
      fall  = psck && !sck;
      sel   = pfsn && !fsn;
      desel = !pfsn && fsn;
      if (rise && fsn) e_r2++;
      if (fall && !fsn) begin
        cap = {cap[14:0], sdo};
        fcnt++;
        if (cyc - last_rise != H) e_r2++;
        last_fall = cyc;
      end
      if (rise) begin
        if (fcnt == 0) begin
          if (cyc - fs_fall_cyc < H) e_r4++;
        end else if (fcnt == 8) begin
          gap8 = cyc - last_fall;
        end else if (cyc - last_fall != H) begin
          e_r2++;
        end
        last_rise = cyc;
      end
      if (sel) begin
        if (psck || sck) e_r4++;
        if (seen_rise && (cyc - fs_rise_cyc != G)) e_r6++;
        fs_fall_cyc = cyc;
      end
      if (desel) begin
        seen_rise   = 1;
        fs_rise_cyc = cyc;
        if (fcnt != 0) begin
          if (cyc - last_fall < H) e_r5++;
          last_cap  = cap;
          last_fcnt = fcnt;
          frames++;
          fcnt = 0;
        end
      end
      if ((sdo != psdo) && !rise && !desel) e_r3++;
      if (pbusy && !busy && !sel) e_r8++;
      if (!busy && (sck || sdo || fsn)) e_r7++;
      psck = sck; pfsn = fsn; psdo = sdo; pbusy = busy;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive_req(input logic [15:0] stim);
    split = stim[15];
    chan  = stim[14];
    mode  = stim[13:12];
    data  = stim[11:0];
  endtask

  task automatic send(input logic [15:0] stim, input logic [15:0] exp);
    int f0;
    while (busy) @(negedge clk);
    f0 = frames;
    drive_req(stim);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R8 busy after start", int'(busy), 1);
    drive_req(~stim);  // R9: inputs change after acceptance
    while (busy) @(negedge clk);
    chk(last_cap == exp, "R1 frame word", int'(last_cap), int'(exp));
    chk(last_fcnt == 16, "R1 falling edge count", last_fcnt, 16);
    chk(frames == f0 + 1, "R9 one frame per start", frames - f0, 1);
    chk(gap8 == (stim[15] ? (BG + 1) * H : H), "R10 gap after eighth bit", gap8,
        stim[15] ? (BG + 1) * H : H);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    frames = 0; last_fcnt = 0; last_cap = '0; gap8 = 0;
    e_r2 = 0; e_r3 = 0; e_r4 = 0; e_r5 = 0; e_r6 = 0; e_r7 = 0; e_r8 = 0;
    arst_n = 1'b0;
    start  = 1'b0;
    drive_req(16'h0000);
    repeat (4) @(negedge clk);
    chk({fsn, sck, sdo, busy} == 4'b0, "R7 outputs in reset", {fsn, sck, sdo, busy}, 0);
    arst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk({fsn, sck, sdo, busy} == 4'b0, "R7 outputs after reset", {fsn, sck, sdo, busy}, 0);

    // Vector table
    for (int i = 0; i < 8; i++) begin
      send(VEC[i][31:16], VEC[i][15:0]);
    end

    // R9: start while busy must be ignored
    begin
      int f0;
      f0 = frames;
      drive_req(16'h1234);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (12) @(negedge clk);
      drive_req(16'h6ABC);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (busy) @(negedge clk);
      chk(last_cap == 16'h1234, "R9 frame unchanged by busy start", int'(last_cap), 16'h1234);
      repeat (40) @(negedge clk);
      chk(frames == f0 + 1, "R9 no extra frame", frames - f0, 1);
      chk({fsn, sck, sdo, busy} == 4'b0, "R7 idle after ignored start", {fsn, sck, sdo, busy}, 0);
    end

    // R7: asynchronous reset in the middle of a frame
    drive_req(16'h7FFF);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    arst_n = 1'b0;
    #1;
    chk({fsn, sck, sdo, busy} == 4'b0, "R7 async reset mid-frame", {fsn, sck, sdo, busy}, 0);
    repeat (3) @(negedge clk);
    arst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk({fsn, sck, sdo, busy} == 4'b0, "R7 idle after mid-frame reset", {fsn, sck, sdo, busy}, 0);

    // Recovery frame after reset
    send(16'h2ABC, 16'h2ABC);

    chk(e_r2 == 0, "R2 clock phase timing", e_r2, 0);
    chk(e_r3 == 0, "R3 data changes only on rising edge", e_r3, 0);
    chk(e_r4 == 0, "R4 select fall placement", e_r4, 0);
    chk(e_r5 == 0, "R5 select rise after last edge", e_r5, 0);
    chk(e_r6 == 0, "R6 select high time", e_r6, 0);
    chk(e_r7 == 0, "R7 idle outputs low", e_r7, 0);
    chk(e_r8 == 0, "R8 busy falls with select", e_r8, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule